// File: doc/BRIEF.md
# Programmable Serial Baud Rate Generator

This block produces the bit-rate timing for the receive and transmit halves of a synchronous serial channel. It runs from a base clock. For each direction it emits a one-cycle enable strobe at the programmed rate. It also emits a square-wave clock that changes level on every strobe, so that clock has a 50% duty cycle at half the strobe rate.

The rate of each direction is set by two values. The first is an 8-bit divisor. The second is a power-of-two prescale exponent in the range 0 to 9. Software sets both through a narrow write-only register port, with separate registers for each direction.

A new setting never cuts short the period that is already running. It is taken up when the current period ends. A channel reset command puts every setting back to its default. The default is the fastest rate, where the strobe is high on every cycle.

Top module: `serial_rate_gen`

## Requirements
- R1: Each direction's strobe rises once every D × 2^E base-clock cycles. D is the direction's divisor and E is its exponent. The receive divisor is written at address 0 and the transmit divisor at address 1.
- R2: A divisor value of 0 divides by 256.
- R3: The exponent is taken from bits [3:0] of the write data at address 2 (receive) or address 3 (transmit). Bits [7:4] are ignored. A value from 10 to 15 acts as 9.
- R4: With a divisor of 1 and an exponent of 0, the strobe stays high on every cycle.
- R5: Each direction's clock output is low after any reset. It inverts in the cycle after each of that direction's strobes, and holds its level otherwise.
- R6: A new divisor or exponent is used only from the next period reload. If the write lands in the cycle of a strobe, the period that starts then still uses the old value.
- R7: A write to one direction's registers leaves the other direction's timing unchanged.
- R8: Either reset restores divisor 1 and exponent 0, restarts both counters and drives both clocks low. The two resets are rst_n low, or chan_reset high. A write issued in the same cycle as chan_reset is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_reset | input | 1 | Synchronous channel reset command |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 rx divisor, 1 tx divisor, 2 rx exponent, 3 tx exponent |
| reg_wdata | input | 8 | Write data |
| rx_tick | output | 1 | Receive rate strobe |
| rx_clk | output | 1 | Receive 50% duty clock |
| tx_tick | output | 1 | Transmit rate strobe |
| tx_clk | output | 1 | Transmit 50% duty clock |

## Verification
The divider is tried with several settings, and each one separates a different fault:
- Small divisors with exponent 0 expose off-by-one period errors.
- Combined divisor and exponent settings show whether the two factors multiply.
- A zero divisor shows the 256 encoding.
- A select byte with high bits set, and another with an out-of-range exponent, separate masking from clamping.
- The largest setting, divisor 0 with exponent 9, exercises the full counter width.
- Writes in mid-period, and writes in the exact strobe cycle, show whether settings apply only at reload.
- Channel reset is applied in mid-period and together with a write, to show it takes priority.

// File: rtl/serial_rate_gen.sv
module serial_rate_gen #(
  parameter int TC_W    = 8,
  parameter int EXP_W   = 4,
  parameter int MAX_EXP = 9,
  parameter int RST_TC  = 1,
  parameter int RST_EXP = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chan_reset,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic       rx_tick,
  output logic       rx_clk,
  output logic       tx_tick,
  output logic       tx_clk
);
  localparam int CNT_W    = TC_W + 1 + MAX_EXP;
  localparam int RST_DIV  = (RST_TC == 0) ? (1 << TC_W) : RST_TC;
  localparam int RST_LOAD = (RST_DIV << RST_EXP) - 1;

  logic [1:0] tick_w, clk_w;

  for (genvar d = 0; d < 2; d++) begin : g_dir
    logic [TC_W-1:0]  tc_q;
    logic [EXP_W-1:0] exp_q;
    logic [CNT_W-1:0] cnt_q;
    logic             clk_q;
    logic [TC_W:0]    div_w;
    logic [CNT_W-1:0] load_w;
    logic [EXP_W-1:0] exp_in;
    logic             wr_tc, wr_exp;

    assign div_w  = (tc_q == '0) ? (TC_W+1)'(1 << TC_W) : {1'b0, tc_q};
    assign load_w = (CNT_W'(div_w) << exp_q) - CNT_W'(1);
    assign exp_in = (reg_wdata[EXP_W-1:0] > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP)
                                                              : reg_wdata[EXP_W-1:0];
    assign wr_tc  = reg_we && (reg_addr == {1'b0, 1'(d)});
    assign wr_exp = reg_we && (reg_addr == {1'b1, 1'(d)});

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tc_q  <= TC_W'(RST_TC);
        exp_q <= EXP_W'(RST_EXP);
        cnt_q <= CNT_W'(RST_LOAD);
        clk_q <= 1'b0;
      end else if (chan_reset) begin
        tc_q  <= TC_W'(RST_TC);
        exp_q <= EXP_W'(RST_EXP);
        cnt_q <= CNT_W'(RST_LOAD);
        clk_q <= 1'b0;
      end else begin
        if (cnt_q == '0) begin
          cnt_q <= load_w;
          clk_q <= ~clk_q;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
        if (wr_tc)  tc_q  <= reg_wdata[TC_W-1:0];
        if (wr_exp) exp_q <= exp_in;
      end
    end

    assign tick_w[d] = (cnt_q == '0);
    assign clk_w[d]  = clk_q;
  end

  assign rx_tick = tick_w[0];
  assign tx_tick = tick_w[1];
  assign rx_clk  = clk_w[0];
  assign tx_clk  = clk_w[1];
endmodule

module serial_rate_gen_chk #(
  parameter int TC_W    = 8,
  parameter int MAX_EXP = 9
) (
  input logic clk,
  input logic rst_n,
  input logic chan_reset,
  input logic rx_tick,
  input logic rx_clk,
  input logic tx_tick,
  input logic tx_clk
);
  localparam int GAP_W   = TC_W + MAX_EXP + 2;
  localparam int MAX_PER = (1 << TC_W) << MAX_EXP;

  logic [GAP_W-1:0] rx_gap, tx_gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_gap <= '0;
      tx_gap <= '0;
    end else begin
      rx_gap <= (rx_tick || chan_reset) ? '0 : rx_gap + GAP_W'(1);
      tx_gap <= (tx_tick || chan_reset) ? '0 : tx_gap + GAP_W'(1);
    end
  end

  AST_RX_CLK_FLIPS: assert property (@(posedge clk) disable iff (!rst_n || chan_reset)
    (rx_tick && !chan_reset) |=> (rx_clk != $past(rx_clk))); // R5
  AST_TX_CLK_FLIPS: assert property (@(posedge clk) disable iff (!rst_n || chan_reset)
    (tx_tick && !chan_reset) |=> (tx_clk != $past(tx_clk))); // R5
  AST_RX_CLK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_tick && !chan_reset) |=> $stable(rx_clk)); // R5
  AST_TX_CLK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_tick && !chan_reset) |=> $stable(tx_clk)); // R5
  AST_RESET_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    chan_reset |=> (!rx_clk && !tx_clk)); // R8
  AST_RX_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rx_gap < GAP_W'(MAX_PER)); // R1
  AST_TX_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_gap < GAP_W'(MAX_PER)); // R1
endmodule

bind serial_rate_gen serial_rate_gen_chk #(.TC_W(TC_W), .MAX_EXP(MAX_EXP)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_reset(chan_reset),
  .rx_tick(rx_tick), .rx_clk(rx_clk), .tx_tick(tx_tick), .tx_clk(tx_clk)
);

// File: tb/serial_rate_gen_tb.sv
`timescale 1ns/1ps
module serial_rate_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chan_reset = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic rx_tick, rx_clk, tx_tick, tx_clk;

  int checks = 0;
  int fails = 0;
  string req = "R8";

  int m_tc [2];
  int m_exp[2];
  int m_rem[2];
  int m_clk[2];

  always #10 clk = ~clk;

  serial_rate_gen u_dut (
    .clk(clk), .rst_n(rst_n), .chan_reset(chan_reset),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rx_tick(rx_tick), .rx_clk(rx_clk), .tx_tick(tx_tick), .tx_clk(tx_clk)
  );

  function automatic int period(int tc, int ex);
    int div;
    div = (tc == 0) ? 256 : tc;
    return div * (1 << ex);
  endfunction

  task automatic model_reset();
    for (int d = 0; d < 2; d++) begin
      m_tc[d] = 1; m_exp[d] = 0; m_rem[d] = 0; m_clk[d] = 0;
    end
  endtask

  initial model_reset();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || chan_reset) begin
      model_reset();
    end else begin
      for (int d = 0; d < 2; d++) begin
        if (m_rem[d] == 0) begin
          m_rem[d] = period(m_tc[d], m_exp[d]) - 1;
          m_clk[d] = 1 - m_clk[d];
        end else begin
          m_rem[d] = m_rem[d] - 1;
        end
        if (reg_we && reg_addr == 2'(d)) m_tc[d] = int'(reg_wdata);
        if (reg_we && reg_addr == 2'(d + 2)) begin
          m_exp[d] = int'(reg_wdata[3:0]);
          if (m_exp[d] > 9) m_exp[d] = 9;
        end
      end
    end
  end

  always @(negedge clk) begin
    checks++;
    if (rx_tick !== (m_rem[0] == 0) || tx_tick !== (m_rem[1] == 0)) begin
      fails++;
      $display("FAIL %s tick: actual rx=%b tx=%b expected rx=%b tx=%b", req,
               rx_tick, tx_tick, m_rem[0] == 0, m_rem[1] == 0);
    end
    checks++;
    if (rx_clk !== m_clk[0][0] || tx_clk !== m_clk[1][0]) begin
      fails++;
      $display("FAIL R5 (%s) clock: actual rx=%b tx=%b expected rx=%0d tx=%0d", req,
               rx_clk, tx_clk, m_clk[0], m_clk[1]);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    req = "R8";
    idle(3);
    rst_n = 1'b1;
    req = "R4";
    idle(10);
    req = "R1";
    wr(2'd0, 8'd3);
    idle(20);
    wr(2'd3, 8'd2);
    wr(2'd1, 8'd5);
    idle(70);
    req = "R6";
    wr(2'd0, 8'd7);
    idle(30);
    @(negedge clk);
    while (!rx_tick) @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 8'd2;
    @(negedge clk);
    reg_we = 1'b0;
    idle(30);
    req = "R3";
    wr(2'd2, 8'hF2);
    idle(50);
    wr(2'd2, 8'h0C);
    idle(2200);
    req = "R2";
    wr(2'd0, 8'd0);
    wr(2'd2, 8'd0);
    idle(1200);
    req = "R7";
    wr(2'd1, 8'd9);
    wr(2'd3, 8'd1);
    idle(300);
    req = "R8";
    idle(5);
    chan_reset = 1'b1;
    @(negedge clk);
    chan_reset = 1'b0;
    idle(10);
    wr(2'd1, 8'd4);
    @(negedge clk);
    chan_reset = 1'b1; reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 8'd6;
    @(negedge clk);
    chan_reset = 1'b0; reg_we = 1'b0;
    idle(20);
    req = "R1";
    wr(2'd0, 8'd0);
    wr(2'd2, 8'd9);
    idle(131200);
    finish_run();
  end
endmodule